// File: doc/BRIEF.md
# Core Idle-State Controller

This block decides which idle power state a single processor core occupies. Requests decoded from the core (a halt instruction, a monitor-wait instruction with a target depth, and I/O reads of the level-2 and level-3 power registers) move the core from the active state into a shallow halt, a deeper clock-gated level-2 state, or the deepest level-3 state. Level 3 is entered only after the private caches have been written back. Interrupt-class wake events bring the core back to the active state. A monitor event can also wake the core, but only when the monitor is armed and the idle state was entered through monitor-wait.

While the core is shallow-idle, bus snoops and accesses from the other core are handled in a short service sub-state. The controller then returns to the idle state it came from. In level 3 such traffic is absorbed without waking the core, and the core clock stays off. A stop-clock request from the system parks a shallow-idle core in a stop-grant state and acknowledges it with a one-cycle pulse. When stop-clock is released, the core returns to the same idle state.

All outputs come from registers, so every reaction appears on the clock edge after the input that caused it.

Top module: `coreIdleCtrl`

## Requirements
- R1: Reset (rstN low, asynchronous) puts the controller in the active state from any state. While reset is held and right after it: idleState is 0, coreClkEn is 1, and stopGrantAck, flushReq and snoopActive are all 0.
- R2: In the active state, haltReq moves the core to halt-idle. In any idle state (halt, monitor-wait, level 2, level 3), any single bit of wakeSrc returns it to the active state on the next edge. The wakeSrc bits are, from bit 0 up: SMI, INIT, NMI, INTR, interrupt message.
- R3: mwaitDepth selects the monitor-wait target. 1 gives level 2, 2 gives level 3 (through flushing), and 0 or 3 give monitor-wait idle. When several entry requests arrive together, lvl3Read wins over lvl2Read, lvl2Read over mwaitReq, and mwaitReq over haltReq.
- R4: A monitorArm pulse arms the monitor. An armed monitorEvent wakes a core only if it entered idle through monitor-wait. A halt-idle core, or one that entered level 2 or level 3 through a register read, stays where it is. An unarmed monitorEvent wakes nothing.
- R5: stopClk in halt-idle, monitor-wait idle or level 2 moves the core to stop-grant. stopGrantAck is high only in the first cycle there. Wake events are ignored in stop-grant. Dropping stopClk returns the core to its previous idle state. stopClk in the active state changes nothing and gives no acknowledge. A wake event in the same cycle as stopClk wins.
- R6: busSnoop or peerAccess in halt-idle, monitor-wait idle or level 2 moves the core to the snoop sub-state, with snoopActive high. snoopDone returns it to the idle state it left.
- R7: A level-3 entry first goes to flushing, with flushReq held high until flushDone. Level 3 follows on the edge after flushDone if no snoop is present. Wake events are ignored while flushing.
- R8: A snoop during flushing is serviced first. The core goes to the snoop sub-state and returns to flushing on snoopDone. A flushDone seen meanwhile (even in the snoop's own cycle) is remembered, and level 3 follows one cycle after the return.
- R9: In level 3, coreClkEn is 0. busSnoop and peerAccess neither wake the core nor raise snoopActive.
- R10: A level-3 core wakes on any wakeSrc bit. An armed monitor stays armed through flushing and level 3, so a monitorEvent then wakes a core that entered level 3 through monitor-wait.
- R11: In the active state, a wakeSrc bit in the same cycle as any entry request keeps the core active.
- R12: idleState encodes the state as 0 active, 1 halt-idle, 2 monitor-wait idle, 3 level 2, 4 level 3, 5 snoop service, 6 stop-grant, 7 flushing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haltReq | input | 1 | Halt instruction executed |
| mwaitReq | input | 1 | Monitor-wait instruction executed |
| mwaitDepth | input | DEPTH_W | Monitor-wait target depth |
| lvl2Read | input | 1 | Level-2 power register read |
| lvl3Read | input | 1 | Level-3 power register read |
| wakeSrc | input | NUM_WAKE | Interrupt-class wake events |
| monitorArm | input | 1 | Arms the address monitor |
| monitorEvent | input | 1 | Monitored address was written |
| stopClk | input | 1 | System stop-clock request |
| busSnoop | input | 1 | Snoop from the bus |
| peerAccess | input | 1 | Snoop or cacheable access from the other core |
| snoopDone | input | 1 | Snoop service complete |
| flushDone | input | 1 | Cache write-back complete |
| idleState | output | 3 | Current state encoding |
| coreClkEn | output | 1 | Core clock enable |
| stopGrantAck | output | 1 | One-cycle stop-grant acknowledge |
| flushReq | output | 1 | Cache write-back request |
| snoopActive | output | 1 | Snoop service in progress |

## Verification
The bench provokes two kinds of same-cycle collision. The first is a wake event together with a new entry request or a stop-clock request, where the wake must win. The bench drives both on one edge for every entry kind and every wake bit, and judges the result by idleState staying or returning at 0. The second is a snoop together with flushDone during flushing, where the snoop must be serviced first and the flush completion still remembered. This is judged by the exact sequence 7, 5, 7, 4 on idleState with flushReq falling after the shared edge.

// File: rtl/coreIdlePkg.sv
package coreIdlePkg;

  typedef enum logic [2:0] {
    ST_C0     = 3'd0,
    ST_C1H    = 3'd1,
    ST_C1M    = 3'd2,
    ST_C2     = 3'd3,
    ST_C3     = 3'd4,
    ST_SNOOP  = 3'd5,
    ST_STPGNT = 3'd6,
    ST_FLUSH  = 3'd7
  } idleState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic saveRet;     // remember current state as the return point
    logic setVia;      // idle entry through monitor-wait
    logic clrVia;      // idle entry through halt or register read
    logic startFlush;  // raise the write-back request
    logic monConsume;  // monitor event used as a wake
    logic ackPulse;    // stop-grant acknowledge next cycle
  } idleStrobe_t;

endpackage

// File: rtl/coreIdleFsm.sv
module coreIdleFsm
  import coreIdlePkg::*;
#(
  parameter int DEPTH_W  = 2,
  parameter int NUM_WAKE = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                haltReq,
  input  logic                mwaitReq,
  input  logic [DEPTH_W-1:0]  mwaitDepth,
  input  logic                lvl2Read,
  input  logic                lvl3Read,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic                monitorEvent,
  input  logic                stopClk,
  input  logic                busSnoop,
  input  logic                peerAccess,
  input  logic                snoopDone,
  input  logic                flushDone,
  input  idleState_e          retState,
  input  logic                viaMwait,
  input  logic                armed,
  input  logic                flushPend,
  output idleState_e          state,
  output idleStrobe_t         strobe
);

  localparam logic [DEPTH_W-1:0] DEPTH_TO_C2 = DEPTH_W'(1);
  localparam logic [DEPTH_W-1:0] DEPTH_TO_C3 = DEPTH_W'(2);

  idleState_e stateQ, nextState;
  logic anyWake, monWake, snoopHit;

  assign anyWake  = |wakeSrc;
  assign monWake  = monitorEvent & armed & viaMwait;
  assign snoopHit = busSnoop | peerAccess;
  assign state    = stateQ;

  always_comb begin
    nextState = stateQ;
    strobe    = '0;
    case (stateQ)
      ST_C0: begin
        if (!anyWake) begin
          if (lvl3Read) begin
            nextState         = ST_FLUSH;
            strobe.startFlush = 1'b1;
            strobe.clrVia     = 1'b1;
          end else if (lvl2Read) begin
            nextState     = ST_C2;
            strobe.clrVia = 1'b1;
          end else if (mwaitReq) begin
            strobe.setVia = 1'b1;
            if (mwaitDepth == DEPTH_TO_C2) begin
              nextState = ST_C2;
            end else if (mwaitDepth == DEPTH_TO_C3) begin
              nextState         = ST_FLUSH;
              strobe.startFlush = 1'b1;
            end else begin
              nextState = ST_C1M;
            end
          end else if (haltReq) begin
            nextState     = ST_C1H;
            strobe.clrVia = 1'b1;
          end
        end
      end
      ST_C1H, ST_C1M, ST_C2: begin
        if (anyWake || monWake) begin
          nextState         = ST_C0;
          strobe.monConsume = monWake;
        end else if (stopClk) begin
          nextState       = ST_STPGNT;
          strobe.saveRet  = 1'b1;
          strobe.ackPulse = 1'b1;
        end else if (snoopHit) begin
          nextState      = ST_SNOOP;
          strobe.saveRet = 1'b1;
        end
      end
      ST_C3: begin
        if (anyWake || monWake) begin
          nextState         = ST_C0;
          strobe.monConsume = monWake;
        end
      end
      ST_FLUSH: begin
        if (snoopHit) begin
          nextState      = ST_SNOOP;
          strobe.saveRet = 1'b1;
        end else if (flushDone || !flushPend) begin
          nextState = ST_C3;
        end
      end
      ST_SNOOP: begin
        if (snoopDone) nextState = retState;
      end
      ST_STPGNT: begin
        if (!stopClk) nextState = retState;
      end
      default: nextState = ST_C0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_C0;
    else       stateQ <= nextState;
  end

  assert_wake_beats_entry_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_C0 && anyWake) |=> stateQ == ST_C0);

  assert_c3_only_after_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_FLUSH && stateQ != ST_C3) |=> stateQ != ST_C3);

  assert_c3_keeps_on_snoop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_C3 && !anyWake && !monitorEvent) |=> stateQ == ST_C3);

  assert_snoop_returns_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SNOOP && snoopDone) |=> stateQ == $past(retState));

  assert_stopgrant_returns_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STPGNT && !stopClk) |=> stateQ == $past(retState));

endmodule

// File: rtl/coreIdleDp.sv
module coreIdleDp
  import coreIdlePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  idleState_e  state,
  input  idleStrobe_t strobe,
  input  logic        monitorArm,
  input  logic        flushDone,
  output idleState_e  retState,
  output logic        viaMwait,
  output logic        armed,
  output logic        flushPend,
  output logic        ackOut
);

  idleState_e retQ;
  logic viaQ, armedQ, flushPendQ, ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retQ       <= ST_C0;
      viaQ       <= 1'b0;
      armedQ     <= 1'b0;
      flushPendQ <= 1'b0;
      ackQ       <= 1'b0;
    end else begin
      if (strobe.saveRet) retQ <= state;
      if (strobe.setVia)      viaQ <= 1'b1;
      else if (strobe.clrVia) viaQ <= 1'b0;
      if (monitorArm)             armedQ <= 1'b1;
      else if (strobe.monConsume) armedQ <= 1'b0;
      if (strobe.startFlush) flushPendQ <= 1'b1;
      else if (flushDone)    flushPendQ <= 1'b0;
      ackQ <= strobe.ackPulse;
    end
  end

  assign retState  = retQ;
  assign viaMwait  = viaQ;
  assign armed     = armedQ;
  assign flushPend = flushPendQ;
  assign ackOut    = ackQ;

  assert_monitor_kept_in_c3_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_C3 || state == ST_FLUSH) && armedQ && !strobe.monConsume) |=> armedQ);

  assert_flush_req_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_C3) |-> !flushPendQ);

endmodule

// File: rtl/coreIdleCtrl.sv
module coreIdleCtrl
  import coreIdlePkg::*;
#(
  parameter int DEPTH_W  = 2,
  parameter int NUM_WAKE = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                haltReq,
  input  logic                mwaitReq,
  input  logic [DEPTH_W-1:0]  mwaitDepth,
  input  logic                lvl2Read,
  input  logic                lvl3Read,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic                monitorArm,
  input  logic                monitorEvent,
  input  logic                stopClk,
  input  logic                busSnoop,
  input  logic                peerAccess,
  input  logic                snoopDone,
  input  logic                flushDone,
  output logic [2:0]          idleState,
  output logic                coreClkEn,
  output logic                stopGrantAck,
  output logic                flushReq,
  output logic                snoopActive
);

  idleState_e  state, retState;
  idleStrobe_t strobe;
  logic viaMwait, armed, flushPend, ackOut;

  coreIdleFsm #(.DEPTH_W(DEPTH_W), .NUM_WAKE(NUM_WAKE)) i_fsm (
    .clk(clk), .rstN(rstN),
    .haltReq(haltReq), .mwaitReq(mwaitReq), .mwaitDepth(mwaitDepth),
    .lvl2Read(lvl2Read), .lvl3Read(lvl3Read), .wakeSrc(wakeSrc),
    .monitorEvent(monitorEvent), .stopClk(stopClk),
    .busSnoop(busSnoop), .peerAccess(peerAccess),
    .snoopDone(snoopDone), .flushDone(flushDone),
    .retState(retState), .viaMwait(viaMwait), .armed(armed),
    .flushPend(flushPend), .state(state), .strobe(strobe)
  );

  coreIdleDp i_dp (
    .clk(clk), .rstN(rstN), .state(state), .strobe(strobe),
    .monitorArm(monitorArm), .flushDone(flushDone),
    .retState(retState), .viaMwait(viaMwait), .armed(armed),
    .flushPend(flushPend), .ackOut(ackOut)
  );

  assign idleState    = state;
  assign coreClkEn    = (state != ST_C3);
  assign snoopActive  = (state == ST_SNOOP);
  assign flushReq     = flushPend;
  assign stopGrantAck = ackOut;

  assert_ack_needs_stopclk_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopGrantAck |-> ($past(stopClk) && state == ST_STPGNT));

  assert_ack_single_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopGrantAck |=> !stopGrantAck);

endmodule

// File: tb/test_coreIdleCtrl.sv
module test_coreIdleCtrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 0, mwaitReq = 0, lvl2Read = 0, lvl3Read = 0;
  logic [1:0] mwaitDepth = 0;
  logic [4:0] wakeSrc = 0;
  logic monitorArm = 0, monitorEvent = 0, stopClk = 0;
  logic busSnoop = 0, peerAccess = 0, snoopDone = 0, flushDone = 0;
  logic [2:0] idleState;
  logic coreClkEn, stopGrantAck, flushReq, snoopActive;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  coreIdleCtrl i_coreIdleCtrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .mwaitReq(mwaitReq),
    .mwaitDepth(mwaitDepth), .lvl2Read(lvl2Read), .lvl3Read(lvl3Read),
    .wakeSrc(wakeSrc), .monitorArm(monitorArm), .monitorEvent(monitorEvent),
    .stopClk(stopClk), .busSnoop(busSnoop), .peerAccess(peerAccess),
    .snoopDone(snoopDone), .flushDone(flushDone), .idleState(idleState),
    .coreClkEn(coreClkEn), .stopGrantAck(stopGrantAck), .flushReq(flushReq),
    .snoopActive(snoopActive)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearIn();
    haltReq = 0; mwaitReq = 0; mwaitDepth = 0; lvl2Read = 0; lvl3Read = 0;
    wakeSrc = 0; monitorArm = 0; monitorEvent = 0; stopClk = 0;
    busSnoop = 0; peerAccess = 0; snoopDone = 0; flushDone = 0;
  endtask

  task automatic doReset();
    clearIn();
    rstN = 0;
    step();
    step();
    rstN = 1;
    step();
  endtask

  // entry kinds: 0 halt, 1 mwait d0, 2 mwait d3, 3 lvl2, 4 mwait d1, 5 lvl3, 6 mwait d2
  function automatic int expIdle(input int k);
    case (k)
      0: return 1;
      1, 2: return 2;
      3, 4: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic bit viaM(input int k);
    return (k == 1 || k == 2 || k == 4 || k == 6);
  endfunction

  task automatic driveEntry(input int k);
    case (k)
      0: haltReq = 1;
      1: begin mwaitReq = 1; mwaitDepth = 0; end
      2: begin mwaitReq = 1; mwaitDepth = 3; end
      3: lvl2Read = 1;
      4: begin mwaitReq = 1; mwaitDepth = 1; end
      5: lvl3Read = 1;
      default: begin mwaitReq = 1; mwaitDepth = 2; end
    endcase
  endtask

  task automatic enterIdle(input int k);
    driveEntry(k);
    step();
    haltReq = 0; mwaitReq = 0; mwaitDepth = 0; lvl2Read = 0; lvl3Read = 0;
    if (k >= 5) begin
      flushDone = 1;
      step();
      flushDone = 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    clearIn();
    step();
    chk("R1 state in reset", idleState, 0);
    chk("R1 clkEn in reset", coreClkEn, 1);
    rstN = 1;
    step();
    chk("R1 state", idleState, 0);
    chk("R1 ack", stopGrantAck, 0);
    chk("R1 flushReq", flushReq, 0);
    chk("R1 snoopActive", snoopActive, 0);

    // R2 R3 R10 R12: each entry kind, each wake bit
    for (int k = 0; k < 7; k++) begin
      for (int b = 0; b < 5; b++) begin
        enterIdle(k);
        chk("R3 entry state", idleState, expIdle(k));
        chk("R9 clkEn", coreClkEn, (expIdle(k) == 4) ? 0 : 1);
        wakeSrc[b] = 1;
        step();
        wakeSrc = 0;
        chk("R2 wake to active", idleState, 0);
      end
    end

    // R4 R10: monitor wake depends on arming and on entry through monitor-wait
    for (int k = 0; k < 7; k++) begin
      for (int arm = 0; arm < 2; arm++) begin
        doReset();
        if (arm == 1) begin
          monitorArm = 1;
          step();
          monitorArm = 0;
        end
        enterIdle(k);
        monitorEvent = 1;
        step();
        monitorEvent = 0;
        chk("R4 monitor wake", idleState, (arm == 1 && viaM(k)) ? 0 : expIdle(k));
        if (idleState != 0) begin
          wakeSrc[4] = 1;
          step();
          wakeSrc = 0;
        end
      end
    end

    // R5: stop-grant from each shallow idle state
    doReset();
    stopClk = 1;
    step();
    chk("R5 stopClk in active state", idleState, 0);
    chk("R5 no ack in active state", stopGrantAck, 0);
    stopClk = 0;
    for (int k = 0; k < 5; k++) begin
      enterIdle(k);
      stopClk = 1;
      step();
      chk("R5 stop-grant state", idleState, 6);
      chk("R5 ack first cycle", stopGrantAck, 1);
      wakeSrc[0] = 1;
      step();
      wakeSrc = 0;
      chk("R5 ack drops", stopGrantAck, 0);
      chk("R5 wake ignored in stop-grant", idleState, 6);
      stopClk = 0;
      step();
      chk("R5 return after stop-clock", idleState, expIdle(k));
      stopClk = 1;
      wakeSrc[2] = 1;
      step();
      stopClk = 0;
      wakeSrc = 0;
      chk("R5 wake beats stop-clock", idleState, 0);
      chk("R5 no ack when wake wins", stopGrantAck, 0);
    end

    // R6: snoop service from shallow idle
    for (int k = 0; k < 5; k++) begin
      for (int src = 0; src < 2; src++) begin
        enterIdle(k);
        if (src == 0) busSnoop = 1; else peerAccess = 1;
        step();
        busSnoop = 0; peerAccess = 0;
        chk("R6 snoop state", idleState, 5);
        chk("R6 snoopActive", snoopActive, 1);
        step();
        chk("R6 holds until done", idleState, 5);
        snoopDone = 1;
        step();
        snoopDone = 0;
        chk("R6 return to origin", idleState, expIdle(k));
        chk("R6 snoopActive low", snoopActive, 0);
        wakeSrc[1] = 1;
        step();
        wakeSrc = 0;
      end
    end

    // R9: level 3 ignores snoops and peer accesses
    for (int k = 5; k < 7; k++) begin
      enterIdle(k);
      busSnoop = 1; peerAccess = 1;
      for (int c = 0; c < 3; c++) begin
        step();
        chk("R9 stays in level 3", idleState, 4);
        chk("R9 snoopActive low", snoopActive, 0);
        chk("R9 clock off", coreClkEn, 0);
      end
      busSnoop = 0; peerAccess = 0;
      wakeSrc[3] = 1;
      step();
      wakeSrc = 0;
      chk("R10 wake from level 3", idleState, 0);
      chk("R10 clock back on", coreClkEn, 1);
    end

    // R7: flush handshake
    lvl3Read = 1;
    step();
    lvl3Read = 0;
    chk("R7 flushing", idleState, 7);
    chk("R7 flushReq", flushReq, 1);
    wakeSrc[0] = 1;
    for (int c = 0; c < 3; c++) begin
      step();
      chk("R7 waits for flushDone", idleState, 7);
    end
    wakeSrc = 0;
    flushDone = 1;
    step();
    flushDone = 0;
    chk("R7 level 3 after flushDone", idleState, 4);
    chk("R7 flushReq low", flushReq, 0);
    wakeSrc[0] = 1;
    step();
    wakeSrc = 0;

    // R8: snoop during flushing, then with flushDone in the same cycle
    for (int same = 0; same < 2; same++) begin
      lvl3Read = 1;
      step();
      lvl3Read = 0;
      busSnoop = 1;
      flushDone = (same == 1);
      step();
      busSnoop = 0;
      flushDone = 0;
      chk("R8 snoop first", idleState, 5);
      chk("R8 flushReq after shared edge", flushReq, (same == 1) ? 0 : 1);
      snoopDone = 1;
      step();
      snoopDone = 0;
      chk("R8 back to flushing", idleState, 7);
      if (same == 0) begin
        flushDone = 1;
        step();
        flushDone = 0;
      end else begin
        step();
      end
      chk("R8 level 3 reached", idleState, 4);
      wakeSrc[4] = 1;
      step();
      wakeSrc = 0;
    end

    // R11: wake together with each entry request
    for (int k = 0; k < 7; k++) begin
      for (int b = 0; b < 5; b++) begin
        driveEntry(k);
        wakeSrc[b] = 1;
        step();
        clearIn();
        chk("R11 wake beats entry", idleState, 0);
        chk("R11 no flush request", flushReq, 0);
      end
    end

    // R3: entry priority
    lvl3Read = 1; lvl2Read = 1; haltReq = 1; mwaitReq = 1;
    step();
    clearIn();
    chk("R3 lvl3 wins", idleState, 7);
    doReset();
    lvl2Read = 1; mwaitReq = 1; mwaitDepth = 0; haltReq = 1;
    step();
    clearIn();
    chk("R3 lvl2 wins", idleState, 3);
    doReset();
    mwaitReq = 1; mwaitDepth = 0; haltReq = 1;
    step();
    clearIn();
    chk("R3 mwait wins over halt", idleState, 2);

    // R1: asynchronous reset from level 3
    doReset();
    enterIdle(6);
    chk("R1 in level 3 before reset", idleState, 4);
    #3 rstN = 0;
    #1;
    chk("R1 async reset state", idleState, 0);
    chk("R1 async reset clkEn", coreClkEn, 1);
    step();
    rstN = 1;
    step();
    chk("R1 active after release", idleState, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule